// File: doc/BRIEF.md
# Strap-Captured Boot Configuration Register

This block is a 96-bit configuration register that holds a node's identity and the number of the configuration bus it answers on. Software reaches it through three 32-bit windows selected by a dword index, with a byte-enable mask on every write. All live fields sit in the top window (bits 95:64). The two lower windows read as zero in this block, and writes to them are ignored.

While the active-low reset input is held, the register keeps loading the node-ID and bus-ID strap pins. The values present at the clock edge on which reset is released therefore become the power-up defaults. After that, software may overwrite them. The upper five bus-number bits come up as all ones. A read-only bit mirrors the live CPU-present pin, and a software-owned flag records that node initialization is done. The node ID and the full bus number are driven on output ports at all times, for the logic that builds link idle messages.

Bus number zero is reserved for the compatibility bus. A write whose low data byte would set the bus number to zero leaves the whole bus number unchanged. Any other enabled field in the same write still takes the new data.

Top module: `boot_cfg_reg`

## Requirements
- R1: On the clock edge that ends reset, the node ID takes the value of `node_strap_i`, bus bits 2:0 take the value of `bus_strap_i`, bus bits 7:3 become 11111b and the init-done flag becomes 0. Later changes on the strap pins have no effect.
- R2: A read of window index 2 returns the bus number in bits 7:0 (low three bits in 2:0, high five bits in 7:3), the node ID in bits 12:8, the init-done flag in bit 13, the CPU-present bit in bit 14, and zero in bits 31:15.
- R3: Reads of window indices 0, 1 and 3 return zero. Writes to those indices change no field.
- R4: Read bit 14 of window 2 follows `cpu_pres_i` in the same cycle. Writing that bit has no effect.
- R5: A write to window 2 updates only the bytes whose `be_i` bit is set. Byte 0 carries the bus number, and byte 1 carries the node ID and the init-done flag. The new value is visible from the cycle after the write edge.
- R6: A write to window 2 with `be_i[0]` set and `wdata_i[7:0]` equal to zero leaves the bus number unchanged. An enabled byte 1 in the same write is still applied. As a result, the bus number is never zero after reset, as long as the bus strap or the high-bits default is nonzero.
- R7: `node_id_o` and `bus_num_o` always equal the node-ID and bus fields that a window 2 read returns.
- R8: No field changes in a cycle where `sel_i` or `wr_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. The straps are captured while it is low. |
| node_strap_i | input | 5 | Node-ID strap pins |
| bus_strap_i | input | 3 | Low bus-number strap pins |
| cpu_pres_i | input | 1 | CPU-present pin |
| sel_i | input | 1 | Access select |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Dword window index |
| be_i | input | 4 | Byte enables for the write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| node_id_o | output | 5 | Current node ID |
| bus_num_o | output | 8 | Current bus number |

## Verification
The hardest case to reach is a refused bus write that also carries an enabled byte 1. It only arises when the low data byte is exactly zero, which random data would almost never produce. The stimulus therefore forces the low byte to zero in about a quarter of its writes and also issues the combined case directly. Strap capture needs reset to be pulsed with known strap values and the straps changed afterwards. A second reset with an all-zero bus strap shows the high default bits keeping the bus number nonzero.

// File: rtl/boot_cfg_reg.sv
module boot_cfg_reg #(
  parameter logic [4:0] BUS_HI_RST = 5'h1F,
  parameter logic [1:0] CFG_WIN    = 2'd2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  node_strap_i,
  input  logic [2:0]  bus_strap_i,
  input  logic        cpu_pres_i,
  input  logic        sel_i,
  input  logic        wr_i,
  input  logic [1:0]  addr_i,
  input  logic [3:0]  be_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic [4:0]  node_id_o,
  output logic [7:0]  bus_num_o
);

  logic [4:0] node_q;
  logic [7:0] bus_q;
  logic       init_q;

  wire wr_hit  = sel_i & wr_i & (addr_i == CFG_WIN);
  wire bus_ok  = wr_hit & be_i[0] & (wdata_i[7:0] != 8'd0);
  wire byte1_w = wr_hit & be_i[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      node_q <= node_strap_i;
      bus_q  <= {BUS_HI_RST, bus_strap_i};
      init_q <= 1'b0;
    end else begin
      if (bus_ok) bus_q <= wdata_i[7:0];
      if (byte1_w) begin
        node_q <= wdata_i[12:8];
        init_q <= wdata_i[13];
      end
    end
  end

  assign rdata_o   = (addr_i == CFG_WIN) ? {17'd0, cpu_pres_i, init_q, node_q, bus_q} : 32'd0;
  assign node_id_o = node_q;
  assign bus_num_o = bus_q;

  a_r1_hi_default: assert property (@(posedge clk)
    $rose(rst_n) |-> bus_num_o[7:3] == BUS_HI_RST);

  a_r6_refuse_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && wr_i && addr_i == CFG_WIN && be_i[0] && wdata_i[7:0] == 8'd0)
      |=> $stable(bus_num_o));

  a_r5_bus_write: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && wr_i && addr_i == CFG_WIN && be_i[0] && wdata_i[7:0] != 8'd0)
      |=> bus_num_o == $past(wdata_i[7:0]));

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_i && wr_i) |=> ($stable(bus_num_o) && $stable(node_id_o)));

  a_r3_other_windows: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && wr_i && addr_i != CFG_WIN) |=> ($stable(bus_num_o) && $stable(node_id_o)));

endmodule

// File: tb/boot_cfg_reg_test.sv
module boot_cfg_reg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  node_strap_i = '0;
  logic [2:0]  bus_strap_i = '0;
  logic        cpu_pres_i = 1'b0;
  logic        sel_i = 1'b0, wr_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [3:0]  be_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [4:0]  node_id_o;
  logic [7:0]  bus_num_o;

  int checks = 0, fails = 0;
  logic [4:0] m_node;
  logic [7:0] m_bus;
  logic       m_init;

  boot_cfg_reg uut (.*);

  always #5 clk = ~clk;

  function automatic logic [31:0] exp_read(input logic [1:0] a, input logic cp);
    return (a == 2'd2) ? {17'd0, cp, m_init, m_node, m_bus} : 32'd0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [4:0] ns, input logic [2:0] bs);
    @(negedge clk);
    rst_n = 1'b0; node_strap_i = ns; bus_strap_i = bs;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_node = ns; m_bus = {5'h1F, bs}; m_init = 1'b0;
    @(negedge clk);
    node_strap_i = ~ns; bus_strap_i = ~bs;
  endtask

  task automatic access(input logic s, input logic w, input logic [1:0] a,
                        input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    sel_i = s; wr_i = w; addr_i = a; be_i = be; wdata_i = d;
    if (s && w && a == 2'd2) begin
      if (be[0] && d[7:0] != 8'd0) m_bus = d[7:0];
      if (be[1]) begin m_node = d[12:8]; m_init = d[13]; end
    end
    @(negedge clk);
    sel_i = 1'b0; wr_i = 1'b0;
  endtask

  task automatic read_check(input string req, input logic [1:0] a);
    addr_i = a;
    #1;
    check(req, rdata_o, exp_read(a, cpu_pres_i));
    check("R7 node", {27'd0, node_id_o}, {27'd0, m_node});
    check("R7 bus", {24'd0, bus_num_o}, {24'd0, m_bus});
  endtask

  initial begin
    fork
      begin
        do_reset(5'h13, 3'h5);
        read_check("R1 strap capture", 2'd2);
        repeat (2) @(negedge clk);
        read_check("R1 straps ignored later", 2'd2);
        cpu_pres_i = 1'b1;
        read_check("R4 cpu present 1", 2'd2);
        access(1, 1, 2'd2, 4'hF, 32'h0000_4000);
        read_check("R4 write to cpu bit ignored", 2'd2);
        access(1, 1, 2'd2, 4'h3, 32'h0000_2A00);
        read_check("R6 zero bus refused, byte1 applied", 2'd2);
        access(1, 1, 2'd2, 4'h1, 32'h0000_FF42);
        read_check("R5 byte0 only", 2'd2);
        access(1, 1, 2'd0, 4'hF, 32'hFFFF_FFFF);
        read_check("R3 window0 write ignored", 2'd2);
        read_check("R3 window0 reads zero", 2'd0);
        read_check("R3 window1 reads zero", 2'd1);
        read_check("R3 window3 reads zero", 2'd3);
        access(0, 1, 2'd2, 4'hF, 32'h0000_1F77);
        read_check("R8 unselected write ignored", 2'd2);
        access(1, 0, 2'd2, 4'hF, 32'h0000_1F77);
        read_check("R8 read does not write", 2'd2);
        do_reset(5'h00, 3'h0);
        read_check("R1 zero strap gives nonzero bus R6", 2'd2);
        check("R6 bus nonzero", {31'd0, bus_num_o != 8'd0}, 32'd1);
        void'($urandom(32'd1234));
        for (int i = 0; i < 400; i++) begin
          logic [31:0] d;
          d = $urandom;
          if (($urandom % 4) == 0) d[7:0] = 8'd0;
          cpu_pres_i = $urandom;
          access(($urandom % 5) != 0, ($urandom % 4) != 0, $urandom,
                 $urandom, d);
          read_check("R2 R5 random access", $urandom);
        end
      end
      begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule